// File: doc/BRIEF.md
# Serial Receive Idle-Line Detector

This block sits beside a serial receiver and decides when the receive line has gone quiet. It watches the synchronized line level, a one-cycle tick per bit time, and two frame-position markers from the receiver: one for the end of the start bit and one for the end of the stop bit. It counts bit times during which the line is high. When that count reaches a full character time, it raises an idle flag. A full character time is 10 bit times for 8-bit characters and 11 bit times for 9-bit characters.

A control input chooses where counting begins. With counting from the start bit, high data bits at the tail of a character and the stop bit already count toward the idle time. With counting from the stop bit, only bit times after the stop bit count. The flag works as a one-shot for each received character. A character-received pulse arms the detector, and raising the flag disarms it. A line that stays high for a long time therefore produces a single flag. Software clears the flag with a status read that sees the flag set, followed by a data read.

Top module: `serial_idle_detect`

## Requirements
- R1: After reset `idle_o` is 0 and the detector is disarmed. High bit times before the first `char_rcvd_i` pulse never set `idle_o`. Reset applied while the flag is set returns it to 0.
- R2: With `nine_bit_i`=0 the full character time is 10 high bit times. `idle_o` stays 0 after the 9th counted tick and is 1 in the cycle after the 10th.
- R3: With `nine_bit_i`=1 the full character time is 11 high bit times. `idle_o` stays 0 after the 10th counted tick and is 1 in the cycle after the 11th.
- R4: With `after_stop_i`=0 the counter restarts from zero on `start_mark_i`. Later high data bits, including trailing ones (data is sent least significant bit first), and the stop bit all count.
- R5: With `after_stop_i`=1 the counter restarts from zero on `stop_mark_i`, and ticks between `start_mark_i` and `stop_mark_i` are not counted. A marker that falls in the same cycle as a tick takes priority over that tick.
- R6: A tick that samples `rx_i`=0 sets the count to zero, so counting starts over.
- R7: Setting `idle_o` disarms the detector. After the flag is cleared it stays 0 for any number of further high bit times until a new `char_rcvd_i` pulse arrives.
- R8: `idle_o` clears after `data_rd_i` only when an earlier `status_rd_i` saw `idle_o`=1. A `data_rd_i` with no such status read leaves the flag at 1.
- R9: A `char_rcvd_i` pulse re-arms the detector, so each received character can produce one new flag.
- R10: Only cycles with `bit_tick_i`=1 advance the count. Cycles without a tick have no effect on the count, whatever the line level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Synchronized receive line level |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| start_mark_i | input | 1 | Receiver marker: start bit finished |
| stop_mark_i | input | 1 | Receiver marker: stop bit finished |
| nine_bit_i | input | 1 | 1 selects 9-bit characters (11-bit-time idle span) |
| after_stop_i | input | 1 | 1 starts counting after the stop bit, 0 after the start bit |
| char_rcvd_i | input | 1 | Pulse when a character enters the receive data register |
| status_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| idle_o | output | 1 | Idle-line flag |

## Verification
The bench targets the count boundary for both character lengths. It checks one tick short of the span and then exactly at the span, so a design with an off-by-one span would raise the flag early or late. Characters with different numbers of trailing high bits separate the two counting origins: a design that ignores the origin select would flag too soon or too late after the stop bit. A low tick in the middle of a high stretch, a data read without a prior status read, and a long high line after a clear catch designs that fail to restart the count, clear on a bare data read, or raise the flag more than once for one character.

// File: rtl/idle_det_pkg.sv
package idle_det_pkg;

  // Number of high bit times that make up one full character time.
  function automatic int unsigned idle_span(input int unsigned data_bits,
                                            input logic nine);
    return data_bits + 2 + (nine ? 1 : 0);
  endfunction

endpackage

// File: rtl/idle_origin_ctl.sv
module idle_origin_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_mark,
  input  logic stop_mark,
  input  logic after_stop,
  output logic origin_evt,
  output logic count_en
);

  logic en_q;

  assign origin_evt = after_stop ? stop_mark : start_mark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (origin_evt) begin
      en_q <= 1'b1;
    end else if (after_stop && start_mark) begin
      en_q <= 1'b0;
    end
  end

  assign count_en = en_q;

endmodule

// File: rtl/idle_bit_counter.sv
module idle_bit_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  input  logic             bit_tick,
  input  logic             count_en,
  input  logic             origin_evt,
  input  logic [CNT_W-1:0] span,
  output logic [CNT_W-1:0] cnt_q,
  output logic             span_hit
);

  logic [CNT_W-1:0] span_m1;
  logic             adv;

  assign span_m1  = span - CNT_W'(1);
  assign adv      = bit_tick && rx && count_en && !origin_evt;
  assign span_hit = adv && (cnt_q == span_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (origin_evt) begin
      cnt_q <= '0;
    end else if (bit_tick) begin
      if (!rx) begin
        cnt_q <= '0;
      end else if (count_en && (cnt_q < span)) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/idle_flag_ctl.sv
module idle_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic span_hit,
  input  logic char_rcvd,
  input  logic status_rd,
  input  logic data_rd,
  output logic idle_q,
  output logic armed_q,
  output logic set_evt,
  output logic clr_evt
);

  logic seen_q;

  assign set_evt = span_hit && armed_q;
  assign clr_evt = data_rd && seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      idle_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      if (char_rcvd) begin
        armed_q <= 1'b1;
      end else if (set_evt) begin
        armed_q <= 1'b0;
      end

      if (set_evt) begin
        idle_q <= 1'b1;
      end else if (clr_evt) begin
        idle_q <= 1'b0;
      end

      if (clr_evt) begin
        seen_q <= 1'b0;
      end else if (status_rd) begin
        seen_q <= idle_q;
      end
    end
  end

endmodule

// File: rtl/serial_idle_detect.sv
module serial_idle_detect #(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  input  logic bit_tick_i,
  input  logic start_mark_i,
  input  logic stop_mark_i,
  input  logic nine_bit_i,
  input  logic after_stop_i,
  input  logic char_rcvd_i,
  input  logic status_rd_i,
  input  logic data_rd_i,
  output logic idle_o
);
  import idle_det_pkg::*;

  localparam int unsigned MAX_SPAN = DATA_BITS + 3;
  localparam int unsigned CNT_W    = $clog2(MAX_SPAN + 1);

  logic             origin_evt;
  logic             count_en;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] cnt_q;
  logic             span_hit;
  logic             idle_q;
  logic             armed_q;
  logic             set_evt;
  logic             clr_evt;

  assign span = CNT_W'(idle_span(DATA_BITS, nine_bit_i));

  idle_origin_ctl u_origin (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_mark (start_mark_i),
    .stop_mark  (stop_mark_i),
    .after_stop (after_stop_i),
    .origin_evt (origin_evt),
    .count_en   (count_en)
  );

  idle_bit_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx         (rx_i),
    .bit_tick   (bit_tick_i),
    .count_en   (count_en),
    .origin_evt (origin_evt),
    .span       (span),
    .cnt_q      (cnt_q),
    .span_hit   (span_hit)
  );

  idle_flag_ctl u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .span_hit  (span_hit),
    .char_rcvd (char_rcvd_i),
    .status_rd (status_rd_i),
    .data_rd   (data_rd_i),
    .idle_q    (idle_q),
    .armed_q   (armed_q),
    .set_evt   (set_evt),
    .clr_evt   (clr_evt)
  );

  assign idle_o = idle_q;

endmodule

// File: rtl/serial_idle_detect_chk.sv
module serial_idle_detect_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_i,
  input logic             bit_tick_i,
  input logic             origin_evt,
  input logic             char_rcvd_i,
  input logic             data_rd_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic             armed_q,
  input logic             idle_o,
  input logic             set_evt
);

  a_r5_origin_zero: assert property (@(posedge clk) disable iff (!rst_n)
    origin_evt |=> (cnt_q == '0));

  a_r6_low_tick_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick_i && !rx_i) |=> (cnt_q == '0));

  a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick_i && !origin_evt) |=> $stable(cnt_q));

  a_r7_rise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> $past(armed_q));

  a_r2_rise_on_high_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> $past(bit_tick_i && rx_i));

  a_r8_fall_on_data_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_o) |-> $past(data_rd_i));

  a_r7_disarm_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !char_rcvd_i) |=> !armed_q);

  a_r9_arm_on_char: assert property (@(posedge clk) disable iff (!rst_n)
    char_rcvd_i |=> armed_q);

endmodule

bind serial_idle_detect serial_idle_detect_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_i        (rx_i),
  .bit_tick_i  (bit_tick_i),
  .origin_evt  (origin_evt),
  .char_rcvd_i (char_rcvd_i),
  .data_rd_i   (data_rd_i),
  .cnt_q       (cnt_q),
  .armed_q     (armed_q),
  .idle_o      (idle_o),
  .set_evt     (set_evt)
);

// File: tb/serial_idle_detect_tb_top.sv
`timescale 1ns/1ps
module serial_idle_detect_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_i = 1'b1, bit_tick_i = 1'b0, start_mark_i = 1'b0, stop_mark_i = 1'b0;
  logic nine_bit_i = 1'b0, after_stop_i = 1'b0, char_rcvd_i = 1'b0;
  logic status_rd_i = 1'b0, data_rd_i = 1'b0;
  logic idle_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_idle_detect dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .bit_tick_i(bit_tick_i),
    .start_mark_i(start_mark_i), .stop_mark_i(stop_mark_i),
    .nine_bit_i(nine_bit_i), .after_stop_i(after_stop_i),
    .char_rcvd_i(char_rcvd_i), .status_rd_i(status_rd_i),
    .data_rd_i(data_rd_i), .idle_o(idle_o)
  );

  // {nine_bit, after_stop, data[8:0]}
  localparam int NVEC = 7;
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 9'h0FF},
    {1'b0, 1'b0, 9'h00F},
    {1'b0, 1'b0, 9'h0F0},
    {1'b1, 1'b0, 9'h1FF},
    {1'b1, 1'b1, 9'h1FF},
    {1'b0, 1'b1, 9'h0AA},
    {1'b1, 1'b0, 9'h0C0}
  };

  task automatic step(input logic rx, tk, sm, pm, ch, sr, dr);
    @(negedge clk);
    rx_i = rx; bit_tick_i = tk; start_mark_i = sm; stop_mark_i = pm;
    char_rcvd_i = ch; status_rd_i = sr; data_rd_i = dr;
  endtask

  task automatic high_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1, 1, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic send_frame(input logic nine, input logic [8:0] d);
    int nb;
    nb = nine ? 9 : 8;
    step(0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < nb; i++) step(d[i], 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic clear_seq();
    step(1, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic check(input string req, input logic exp);
    checks++;
    if (idle_o !== exp) begin
      errors++;
      $display("FAIL %s: idle_o=%b expected %b", req, idle_o, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic int ticks_needed(input logic nine, input logic ilt,
                                      input logic [8:0] d);
    int nb, trail;
    nb = nine ? 9 : 8;
    if (ilt) return nb + 2;
    trail = 0;
    for (int i = nb - 1; i >= 0; i--) begin
      if (!d[i]) break;
      trail++;
    end
    return (nb + 2) - (trail + 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset value", 1'b0);
    rst_n = 1'b1;
    // R1: disarmed until the first character
    high_ticks(30);
    check("R1 no flag before first character", 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      logic nine, ilt;
      logic [8:0] d;
      int need;
      nine = VEC[v][10]; ilt = VEC[v][9]; d = VEC[v][8:0];
      need = ticks_needed(nine, ilt, d);
      step(1, 0, 0, 0, 0, 0, 0);
      nine_bit_i = nine; after_stop_i = ilt;
      send_frame(nine, d);
      high_ticks(need - 1);
      check(nine ? "R3 R4 R5 one tick short" : "R2 R4 R5 one tick short", 1'b0);
      high_ticks(1);
      check(nine ? "R3 R9 set at span" : "R2 R9 set at span", 1'b1);
      clear_seq();
      check("R8 clear sequence", 1'b0);
      high_ticks(15);
      check("R7 no second flag", 1'b0);
    end

    // R6: low sample restarts the count (ILT=1, 8-bit)
    nine_bit_i = 1'b0; after_stop_i = 1'b1;
    send_frame(1'b0, 9'h0FF);
    high_ticks(5);
    step(0, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    high_ticks(9);
    check("R6 restart after low tick", 1'b0);
    high_ticks(1);
    check("R6 set after restart", 1'b1);

    // R8: bare data read does not clear
    step(1, 0, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 0, 0);
    check("R8 data read alone keeps flag", 1'b1);
    step(1, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    check("R8 status read alone keeps flag", 1'b1);
    step(1, 0, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 0, 0);
    check("R8 data read after status read clears", 1'b0);

    // R10: cycles without a tick never count
    nine_bit_i = 1'b0; after_stop_i = 1'b1;
    send_frame(1'b0, 9'h055);
    for (int i = 0; i < 9; i++) begin
      step(1, 1, 0, 0, 0, 0, 0);
      repeat (6) step(1, 0, 0, 0, 0, 0, 0);
    end
    check("R10 untimed cycles not counted", 1'b0);
    high_ticks(1);
    check("R10 set on tenth tick", 1'b1);

    // R1: reset while set
    step(1, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    step(1, 0, 0, 0, 0, 0, 0);
    check("R1 reset clears flag", 1'b0);
    rst_n = 1'b1;
    high_ticks(25);
    check("R1 disarmed after reset", 1'b0);

    finish_run();
  end

endmodule